// File: doc/BRIEF.md
# UART Receive Buffer with Interrupt Sources

This block sits between a UART deserializer and a CPU register port. Each incoming character comes with three status flags: break detected, parity error and framing error. The block stores the character and its flags together as one FIFO entry. The CPU pops the oldest entry by reading the data address. The read returns the character, its flags and a valid bit, so software can tell a real entry from a read of an empty buffer.

Three interrupt sources are derived from the buffer state:

- **Overrun**: sticky. It stays set until software resets the buffer.
- **Fill level**: the level has reached a programmable threshold.
- **Idle data**: characters have waited longer than a programmable number of character times.

One register holds the per-source enable bits next to the status bits. The single `irq` output asserts when any enabled source is active. The deserializer supplies a one-cycle `char_tick` pulse once per character time, and the idle timer counts these pulses.

Top module: `rx_fifo_irq`

## Requirements
- R1: A read with `reg_rd` at address 0 pops the oldest stored entry. Data entries come out in arrival order. The read data carries the character in bits [7:0], framing error in bit 8, parity error in bit 9, break in bit 10 and a valid bit of 1 in bit 11. All other bits are 0.
- R2: A read at address 0 while the buffer is empty returns all zeros (valid bit 0) and leaves the level, the flags and the idle timer unchanged.
- R3: The buffer holds 16 entries. A character arriving while the buffer is full, with no pop in the same cycle, is dropped. The stored entries are kept, and overrun status (address 1, bit 8) is set. If a pop happens in the same cycle as the arrival, the character is accepted.
- R4: Overrun status stays set through any number of pops. Only writing 1 to bit 16 of the control register (address 2) clears it. That write also empties the buffer and restarts the idle timer, and a character arriving in the same cycle is dropped.
- R5: Threshold status (address 1, bit 9) is 1 while the fill level is at or above control bits [4:0]. A threshold of 0 keeps this status at 0.
- R6: The idle timer restarts on every accepted push, every successful pop and every buffer reset. It counts `char_tick` pulses only while the buffer is non-empty, saturates at 15, and is held at 0 while the buffer is empty. Timeout status (address 1, bit 10) is 1 while the buffer is non-empty and the count is at least control bits [11:8]. A limit of 0 keeps this status at 0.
- R7: Address 1 bits [2:0] are writable enables for overrun (bit 0), threshold (bit 1) and timeout (bit 2). `irq` is 1 exactly when some status bit is 1 and its enable bit is also 1.
- R8: Address 1 bit 12 reads 1 while the buffer holds at least one entry.
- R9: After reset the buffer is empty, all enables and status bits are 0, and the control register reads 0x108 (threshold 8, timeout 1). Reads of addresses 1 and 2 have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_valid | input | 1 | One-cycle strobe: a received character is presented |
| char_data | input | 8 | Received character |
| char_break | input | 1 | Break detected on this character |
| char_perr | input | 1 | Parity error on this character |
| char_ferr | input | 1 | Framing error on this character |
| char_tick | input | 1 | One pulse per character time |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 data, 1 interrupt, 2 control |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, same cycle |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences cover the boundaries:
- reads of an empty buffer;
- a seventeenth character arriving at a full buffer;
- draining the buffer while overrun status stays set;
- a buffer reset that coincides with an arrival;
- the timeout firing one tick after a single push.

After that, long random runs mix arrivals with random flags, pops, tick pulses, enable writes and control writes with varied thresholds and small timeout limits. These runs separate errors in ordering and flag packing from errors in level counting, timer restart and interrupt masking. A bench model predicts every read value and the `irq` level in every cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              perr;
        logic              ferr;
        logic [CHAR_W-1:0] ch;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);

    // register addresses
    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_INTR = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    // interrupt source indices (enable and status use the same order)
    localparam int SRC_OVR = 0;
    localparam int SRC_THR = 1;
    localparam int SRC_TMO = 2;
    localparam int NSRC    = 3;

    localparam int STAT_LSB   = 8;
    localparam int NE_BIT     = 12;
    localparam int TMO_LSB    = 8;
    localparam int CLR_BIT    = 16;
    localparam int VALID_BIT  = ENTRY_W;
endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         push,
    input  logic                         pop,
    input  rx_entry_t                    wentry,
    output rx_entry_t                    rentry,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         empty,
    output logic                         full,
    output logic                         moved,
    output logic                         dropped
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]      wp;
        logic [PTR_W-1:0]      rp;
        logic [LVL_W-1:0]      lvl;
    } store_t;

    store_t st_d, st_q;
    logic   pop_ok, push_ok;

    always_comb begin
        st_d    = st_q;
        empty   = (st_q.lvl == '0);
        full    = (st_q.lvl == LVL_W'(DEPTH));
        pop_ok  = pop && !empty && !clr;
        push_ok = push && !clr && (!full || pop_ok);
        dropped = push && !clr && !push_ok;
        moved   = pop_ok || push_ok;
        if (clr) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.lvl = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wp] = wentry;
                st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
            end
            if (pop_ok) begin
                st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
            end
            if (push_ok && !pop_ok) begin
                st_d.lvl = st_q.lvl + 1'b1;
            end else if (pop_ok && !push_ok) begin
                st_d.lvl = st_q.lvl - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rentry = st_q.mem[st_q.rp];
    assign level  = st_q.lvl;

    AST_FULL_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (full && $stable(st_q.rp))) else $error("full push"); // R3
    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty) else $error("clear"); // R4
    AST_EMPTY_POP_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (empty && $stable(st_q.rp))) else $error("empty pop"); // R2
endmodule

// File: rtl/rxf_timer.sv
module rxf_timer #(
    parameter int TMO_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             active,
    input  logic             tick,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    localparam logic [TMO_W-1:0] CMAX = '1;

    typedef struct packed {
        logic [TMO_W-1:0] cnt;
    } tmr_t;

    tmr_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (restart || !active) begin
            tm_d.cnt = '0;
        end else if (tick && tm_q.cnt != CMAX) begin
            tm_d.cnt = tm_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign expired = active && (limit != '0) && (tm_q.cnt >= limit);

    AST_TMO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !expired) else $error("restart"); // R6
    AST_TMO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !expired) else $error("idle count"); // R6
endmodule

// File: rtl/rx_fifo_irq.sv
module rx_fifo_irq
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TMO_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              char_break,
    input  logic              char_perr,
    input  logic              char_ferr,
    input  logic              char_tick,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam logic [LVL_W-1:0] THR_RST = LVL_W'(DEPTH/2);
    localparam logic [TMO_W-1:0] TMO_RST = TMO_W'(1);

    typedef struct packed {
        logic [NSRC-1:0]  en;
        logic [LVL_W-1:0] thr;
        logic [TMO_W-1:0] tmo;
        logic             ovr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    rx_entry_t        wentry, rentry;
    logic [LVL_W-1:0] level;
    logic             empty, full, moved, dropped;
    logic             pop_req, clr_req, tmo_hit;
    logic [NSRC-1:0]  stat;

    assign wentry  = '{brk: char_break, perr: char_perr, ferr: char_ferr, ch: char_data};
    assign pop_req = reg_rd && (reg_addr == ADDR_DATA);
    assign clr_req = reg_wr && (reg_addr == ADDR_CTRL) && reg_wdata[CLR_BIT];

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr_req), .push(char_valid), .pop(pop_req),
        .wentry(wentry), .rentry(rentry), .level(level), .empty(empty), .full(full),
        .moved(moved), .dropped(dropped)
    );

    rxf_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(moved || clr_req), .active(!empty),
        .tick(char_tick), .limit(cfg_q.tmo), .expired(tmo_hit)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr && reg_addr == ADDR_INTR) begin
            cfg_d.en = reg_wdata[NSRC-1:0];
        end
        if (reg_wr && reg_addr == ADDR_CTRL) begin
            cfg_d.thr = reg_wdata[LVL_W-1:0];
            cfg_d.tmo = reg_wdata[TMO_LSB +: TMO_W];
        end
        if (clr_req)      cfg_d.ovr = 1'b0;
        else if (dropped) cfg_d.ovr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '{en: '0, thr: THR_RST, tmo: TMO_RST, ovr: 1'b0};
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        stat          = '0;
        stat[SRC_OVR] = cfg_q.ovr;
        stat[SRC_THR] = (cfg_q.thr != '0) && (level >= cfg_q.thr);
        stat[SRC_TMO] = tmo_hit;
    end

    assign irq = |(stat & cfg_q.en);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_DATA: if (!empty) begin
                reg_rdata[ENTRY_W-1:0] = rentry;
                reg_rdata[VALID_BIT]   = 1'b1;
            end
            ADDR_INTR: begin
                reg_rdata[NSRC-1:0]             = cfg_q.en;
                reg_rdata[STAT_LSB +: NSRC]     = stat;
                reg_rdata[NE_BIT]               = !empty;
            end
            ADDR_CTRL: begin
                reg_rdata[LVL_W-1:0]            = cfg_q.thr;
                reg_rdata[TMO_LSB +: TMO_W]     = cfg_q.tmo;
            end
            default: reg_rdata = '0;
        endcase
    end

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.ovr && !clr_req) |=> cfg_q.ovr) else $error("overrun lost"); // R4
    AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        dropped |=> cfg_q.ovr) else $error("overrun not set"); // R3
    AST_CLR_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !cfg_q.ovr) else $error("overrun not cleared"); // R4
endmodule

// File: tb/tb_rx_fifo_irq.sv
`timescale 1ns/1ps
module tb_rx_fifo_irq;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_valid = 1'b0, char_break = 1'b0, char_perr = 1'b0, char_ferr = 1'b0;
    logic [7:0]  char_data = '0;
    logic        char_tick = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #5 clk = ~clk;

    rx_fifo_irq dut (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .char_break(char_break), .char_perr(char_perr), .char_ferr(char_ferr),
        .char_tick(char_tick), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    int tests = 0, fails = 0;
    bit finished = 0;

    // reference model
    logic [10:0] mq[$];
    logic [2:0]  m_en = 0;
    logic [4:0]  m_thr = 5'd8;
    logic [3:0]  m_tmo = 4'd1;
    logic        m_ovr = 0;
    logic [3:0]  m_cnt = 0;

    localparam int OP_NONE = 0, OP_RDD = 1, OP_RDI = 2, OP_RDC = 3, OP_WRI = 4, OP_WRC = 5;

    function automatic logic [2:0] exp_stat();
        logic [2:0] s;
        s[0] = m_ovr;
        s[1] = (m_thr != 0) && (mq.size() >= int'(m_thr));
        s[2] = (mq.size() > 0) && (m_tmo != 0) && (m_cnt >= m_tmo);
        return s;
    endfunction

    function automatic logic [31:0] exp_intr();
        logic [31:0] v = '0;
        v[2:0]  = m_en;
        v[10:8] = exp_stat();
        v[12]   = (mq.size() > 0);
        return v;
    endfunction

    function automatic logic [31:0] exp_ctrl();
        logic [31:0] v = '0;
        v[4:0]  = m_thr;
        v[11:8] = m_tmo;
        return v;
    endfunction

    function automatic logic [31:0] exp_data();
        if (mq.size() == 0) return 32'h0;
        return {20'h0, 1'b1, mq[0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic psh, input logic [10:0] pe, input logic tk,
                        input int op, input logic [31:0] wd);
        logic pop_ok, push_ok, clr, nonempty;
        @(negedge clk);
        char_valid = psh;
        {char_break, char_perr, char_ferr, char_data} = pe;
        char_tick = tk;
        reg_rd = (op == OP_RDD || op == OP_RDI || op == OP_RDC);
        reg_wr = (op == OP_WRI || op == OP_WRC);
        reg_addr = (op == OP_RDD) ? 2'd0 : (op == OP_RDI || op == OP_WRI) ? 2'd1 :
                   (op == OP_RDC || op == OP_WRC) ? 2'd2 : 2'd3;
        reg_wdata = wd;
        #1;
        // R7: irq tracks enabled status
        check("R7 irq", {31'b0, irq}, {31'b0, |(exp_stat() & m_en)});
        if (op == OP_RDD) check("R1/R2 data read", reg_rdata, exp_data());
        if (op == OP_RDI) check("R3 R4 R5 R6 R8 intr read", reg_rdata, exp_intr());
        if (op == OP_RDC) check("R9 ctrl read", reg_rdata, exp_ctrl());
        @(posedge clk);
        clr      = (op == OP_WRC) && wd[16];
        nonempty = (mq.size() > 0);
        pop_ok   = (op == OP_RDD) && nonempty && !clr;
        push_ok  = psh && !clr && (mq.size() < DEPTH || pop_ok);
        if (clr) begin
            mq.delete();
            m_ovr = 0;
        end else begin
            if (pop_ok) void'(mq.pop_front());
            if (push_ok) mq.push_back(pe);
            if (psh && !push_ok) m_ovr = 1;
        end
        if (pop_ok || push_ok || clr || !nonempty) m_cnt = 0;
        else if (tk && m_cnt != 4'hF) m_cnt = m_cnt + 1;
        if (op == OP_WRI) m_en = wd[2:0];
        if (op == OP_WRC) begin
            m_thr = wd[4:0];
            m_tmo = wd[11:8];
        end
    endtask

    task automatic idle(input int op);
        step(0, 11'h0, 0, op, 32'h0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9 reset state
        idle(OP_RDC);
        idle(OP_RDI);
        // R2 empty read returns valid clear, no change
        idle(OP_RDD);
        idle(OP_RDI);
        // enable all sources
        step(0, 0, 0, OP_WRI, 32'h7);
        // R6 single push then one tick fires timeout
        step(1, 11'h5A5, 0, OP_NONE, 0);
        idle(OP_RDI);
        step(0, 0, 1, OP_NONE, 0);
        idle(OP_RDI);
        // R3 fill past depth: 17th character dropped
        for (int i = 1; i <= DEPTH; i++) step(1, 11'((i * 37) ^ (i << 8)), 0, OP_NONE, 0);
        idle(OP_RDI);
        // R1 drain in order; R4 overrun remains set
        for (int i = 0; i < DEPTH; i++) idle(OP_RDD);
        idle(OP_RDI);
        idle(OP_RDD);
        // R4 reset clears overrun; coincident push dropped
        step(1, 11'h123, 0, OP_WRC, 32'h0001_0108);
        idle(OP_RDI);
        // R3 push into full with simultaneous pop is accepted
        for (int i = 0; i < DEPTH; i++) step(1, 11'(i + 3), 0, OP_NONE, 0);
        step(1, 11'h7FF, 0, OP_RDD, 0);
        idle(OP_RDI);
        step(0, 0, 0, OP_WRC, 32'h0001_0108);
        // R5 threshold 0 disables
        step(0, 0, 0, OP_WRC, 32'h0000_0000);
        step(1, 11'h011, 1, OP_NONE, 0);
        idle(OP_RDI);

        // random phase
        for (int n = 0; n < 6000; n++) begin
            int r, op;
            logic [31:0] wd;
            r = int'($urandom_range(0, 99));
            op = (r < 30) ? OP_RDD : (r < 45) ? OP_RDI : (r < 50) ? OP_RDC :
                 (r < 53) ? OP_WRI : (r < 57) ? OP_WRC : OP_NONE;
            wd = '0;
            if (op == OP_WRI) wd[2:0] = 3'($urandom);
            if (op == OP_WRC) begin
                wd[4:0]  = 5'($urandom_range(0, 17));
                wd[11:8] = 4'($urandom_range(0, 4));
                wd[16]   = ($urandom_range(0, 3) == 0);
            end
            step($urandom_range(0, 99) < 40, 11'($urandom), $urandom_range(0, 99) < 25, op, wd);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule